// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block is one bank of general-purpose pins. Each pin has its own control word, which sets the pin as an input or an output and picks the edge that raises an interrupt. The bank also has shared words for the output latch, the sampled input levels, a sticky interrupt status and an interrupt mask. A host reaches all of these through a plain single-cycle register bus. A write is taken on the clock edge where `wr_en` is high. Read data is a combinational function of `addr`.

Pin inputs pass through a two-flop synchroniser, and edges are detected on the synchronised level. A detected edge sets a status bit, and that bit stays set until the host writes a one to it. The single bank interrupt is high while any status bit is set whose mask bit is clear. The mask is set through one address and cleared through another, so the host never needs a read-modify-write. Output set and clear writes do not touch pins that are configured as inputs.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input with edge detection off: control reads 0x1, the output latch is 0, `gpio_oe` is 0, the status is 0, the mask is all ones and `irq` is 0.
- R2: The control word of pin p is at address 0x100 + 4·p. Bit 0 is the direction (1 = input, 0 = output), bits 4:3 are the trigger, and all other bits read as 0. `gpio_oe[p]` is the inverse of the direction bit.
- R3: A write to 0x40 sets, and a write to 0x60 clears, each output latch bit whose data bit is 1 and whose pin is an output. Bits of input pins keep their value. Address 0x00 reads the latch, which drives `gpio_out`.
- R4: Address 0x20 reads the synchronised input levels. A change on `gpio_in` that is present before clock edge k is visible after edge k+1, and not after edge k.
- R5: Trigger code 1 detects rising edges, 2 detects falling edges, 3 detects both, and 0 detects none. A level change present before edge k sets the pin's bit in the status word (read at 0x80) on edge k+2.
- R6: Writing 0x80 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: If an edge is detected for a pin in the same cycle that a write-one-to-clear hits its status bit, the bit is left set.
- R8: Writing ones to 0xA0 sets those mask bits, and writing ones to 0xC0 clears them. Zero bits have no effect. Both addresses read back the mask.
- R9: `irq` is 1 exactly when some bit is set in both the status and the inverted mask. It follows a status or mask update in the same cycle.
- R10: A status bit is sticky. Holding or returning the input level never clears it or sets it again, because only an edge sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| gpio_in | input | NPIN | Pin input levels (asynchronous) |
| gpio_out | output | NPIN | Output latch |
| gpio_oe | output | NPIN | Output enable per pin (1 = driving) |
| irq | output | 1 | Bank interrupt |

## Verification
Two functions can act on one status bit in the same clock: setting it from an edge, and clearing it by write-one-to-clear. The bench first leaves a pin's status bit pending. It then changes that pin's input two cycles ahead, so that the clear write is sampled on exactly the edge where the detection lands. It checks that the bit reads back as set, which shows the edge won over the clear. Separately, an exhaustive sweep runs every pin through every trigger code with both edge directions, and the bench works out the expected status and interrupt from the trigger code alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  localparam logic [7:0] OFS_OUT_VAL  = 8'h00;
  localparam logic [7:0] OFS_IN_VAL   = 8'h20;
  localparam logic [7:0] OFS_OUT_SET  = 8'h40;
  localparam logic [7:0] OFS_OUT_CLR  = 8'h60;
  localparam logic [7:0] OFS_STAT     = 8'h80;
  localparam logic [7:0] OFS_MASK_SET = 8'hA0;
  localparam logic [7:0] OFS_MASK_CLR = 8'hC0;

  localparam int CTRL_DIR_BIT  = 0;
  localparam int CTRL_TRIG_LSB = 3;

  // edge detection for one pin from previous and current synchronised level
  function automatic logic edge_hit_f(trig_e trig, logic prev, logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (trig)
      TRIG_RISE: edge_hit_f = rise;
      TRIG_FALL: edge_hit_f = fall;
      TRIG_BOTH: edge_hit_f = rise | fall;
      default:   edge_hit_f = 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word_f(logic dir, trig_e trig);
    logic [31:0] w;
    w = '0;
    w[CTRL_DIR_BIT] = dir;
    w[CTRL_TRIG_LSB +: 2] = trig;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  logic  wr_dir,
  input  trig_e wr_trig,
  input  logic  level,
  output logic  dir,
  output trig_e trig,
  output logic  hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir    <= 1'b1;
      trig   <= TRIG_OFF;
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (ctrl_we) begin
        dir  <= wr_dir;
        trig <= wr_trig;
      end
    end
  end

  assign hit = edge_hit_f(trig, prev_q, level);
endmodule

// File: rtl/gpio_int_regs.sv
module gpio_int_regs #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] hit,
  input  logic [NPIN-1:0] stat_clr,
  input  logic [NPIN-1:0] mask_set,
  input  logic [NPIN-1:0] mask_clr,
  output logic [NPIN-1:0] status,
  output logic [NPIN-1:0] mask,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      // a fresh edge outranks a clear landing in the same cycle
      status <= (status & ~stat_clr) | hit;
      mask   <= (mask | mask_set) & ~mask_clr;
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPIN-1:0]   gpio_in,
  output logic [NPIN-1:0]   gpio_out,
  output logic [NPIN-1:0]   gpio_oe,
  output logic              irq
);
  localparam int IDX_W = 6;

  logic [NPIN-1:0] level;
  logic [NPIN-1:0] dir_vec;
  logic [NPIN-1:0] trig_off_vec;
  logic [NPIN-1:0] edge_hit;
  logic [NPIN-1:0] stat_clr;
  logic [NPIN-1:0] mask_set;
  logic [NPIN-1:0] mask_clr;
  logic [NPIN-1:0] status_q;
  logic [NPIN-1:0] mask_q;
  logic [NPIN-1:0] out_q;
  logic [NPIN-1:0] set_req;
  logic [NPIN-1:0] clr_req;
  trig_e           trig_vec [NPIN];

  // decode: bank words live in page 0, control words in page 1
  logic             page_bank;
  logic             page_ctrl;
  logic [IDX_W-1:0] ctrl_idx;
  logic             ctrl_hit;

  assign page_bank = (addr[ADDR_W-1:8] == '0);
  assign page_ctrl = (addr[ADDR_W-1:8] == 1) && (addr[1:0] == 2'b00);
  assign ctrl_idx  = addr[7:2];
  assign ctrl_hit  = page_ctrl && (int'(ctrl_idx) < NPIN);

  function automatic logic [NPIN-1:0] strobe_f(logic en, logic sel, logic [31:0] d);
    return (en && sel) ? d[NPIN-1:0] : '0;
  endfunction

  assign set_req  = strobe_f(wr_en, page_bank && addr[7:0] == OFS_OUT_SET,  wdata);
  assign clr_req  = strobe_f(wr_en, page_bank && addr[7:0] == OFS_OUT_CLR,  wdata);
  assign stat_clr = strobe_f(wr_en, page_bank && addr[7:0] == OFS_STAT,     wdata);
  assign mask_set = strobe_f(wr_en, page_bank && addr[7:0] == OFS_MASK_SET, wdata);
  assign mask_clr = strobe_f(wr_en, page_bank && addr[7:0] == OFS_MASK_CLR, wdata);

  gpio_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gpio_in),
    .q     (level)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic we_p;
    assign we_p = wr_en && ctrl_hit && (int'(ctrl_idx) == p);
    gpio_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (we_p),
      .wr_dir  (wdata[CTRL_DIR_BIT]),
      .wr_trig (trig_e'(wdata[CTRL_TRIG_LSB +: 2])),
      .level   (level[p]),
      .dir     (dir_vec[p]),
      .trig    (trig_vec[p]),
      .hit     (edge_hit[p])
    );
    assign trig_off_vec[p] = (trig_vec[p] == TRIG_OFF);
  end

  // output latch: only pins configured as outputs follow set/clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= (out_q | (set_req & ~dir_vec)) & ~(clr_req & ~dir_vec);
  end

  gpio_int_regs #(.NPIN(NPIN)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (edge_hit),
    .stat_clr (stat_clr),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .status   (status_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  function automatic logic [31:0] widen_f(logic [NPIN-1:0] v);
    logic [31:0] w;
    w = '0;
    w[NPIN-1:0] = v;
    return w;
  endfunction

  always_comb begin
    rdata = '0;
    if (page_bank) begin
      case (addr[7:0])
        OFS_OUT_VAL:               rdata = widen_f(out_q);
        OFS_IN_VAL:                rdata = widen_f(level);
        OFS_STAT:                  rdata = widen_f(status_q);
        OFS_MASK_SET, OFS_MASK_CLR: rdata = widen_f(mask_q);
        default:                   rdata = '0;
      endcase
    end else if (ctrl_hit) begin
      for (int p = 0; p < NPIN; p++)
        if (int'(ctrl_idx) == p) rdata = ctrl_word_f(dir_vec[p], trig_vec[p]);
    end
  end

  assign gpio_out = out_q;
  assign gpio_oe  = ~dir_vec;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] gpio_out,
  input logic            irq,
  input logic [NPIN-1:0] int_status,
  input logic [NPIN-1:0] int_mask,
  input logic [NPIN-1:0] edge_hit,
  input logic [NPIN-1:0] stat_clr,
  input logic [NPIN-1:0] dir_in,
  input logic [NPIN-1:0] trig_off
);
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr != '0) |=> ((int_status & $past(stat_clr & ~edge_hit)) == '0)); // R6

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((int_status & $past(edge_hit)) == $past(edge_hit))); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & ~$past(int_status) & ~$past(edge_hit)) == '0)); // R10

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & trig_off) == '0); // R5

  AST_INPUT_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((gpio_out ^ $past(gpio_out)) & $past(dir_in)) == '0)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_status & ~int_mask) == '0) |-> !irq); // R9
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gpio_out   (gpio_out),
  .irq        (irq),
  .int_status (status_q),
  .int_mask   (mask_q),
  .edge_hit   (edge_hit),
  .stat_clr   (stat_clr),
  .dir_in     (dir_vec),
  .trig_off   (trig_off_vec)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NPIN   = 8;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NPIN-1:0]   gpio_in = '0;
  logic [NPIN-1:0]   gpio_out;
  logic [NPIN-1:0]   gpio_oe;
  logic              irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk; // 125 MHz

  gpio_bank #(.NPIN(NPIN), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [ADDR_W-1:0] ctrl_addr(int p);
    return ADDR_W'(12'h100 + 4 * p);
  endfunction

  function automatic logic expect_hit(int trig, logic rising);
    return rising ? (trig == 1 || trig == 3) : (trig == 2 || trig == 3);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(ctrl_addr(0), v);   check("R1 ctrl reset", v, 32'h1);
    bus_rd(12'h000, v);        check("R1 out reset", v, 32'h0);
    bus_rd(12'h080, v);        check("R1 status reset", v, 32'h0);
    bus_rd(12'h0A0, v);        check("R1 mask reset", v, 32'hFF);
    check("R1 oe reset", {24'h0, gpio_oe}, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);

    // R2 control word layout, unused bits read zero
    bus_wr(ctrl_addr(3), 32'hFFFF_FFE6);
    bus_rd(ctrl_addr(3), v);   check("R2 ctrl readback", v, 32'h0000_0000);
    check("R2 oe follows dir", {24'h0, gpio_oe}, 32'h08);
    bus_wr(ctrl_addr(3), 32'h0000_0019);
    bus_rd(ctrl_addr(3), v);   check("R2 ctrl fields", v, 32'h19);
    bus_wr(ctrl_addr(3), 32'h0);

    // R3 set/clear on outputs only: pins 3 output, others input
    bus_wr(12'h040, 32'hFF);
    bus_rd(12'h000, v);        check("R3 set output only", v, 32'h08);
    check("R3 gpio_out", {24'h0, gpio_out}, 32'h08);
    bus_wr(ctrl_addr(5), 32'h0);
    bus_wr(12'h040, 32'h20);
    bus_wr(ctrl_addr(5), 32'h1);
    bus_wr(12'h060, 32'hFF);
    bus_rd(12'h000, v);        check("R3 clear skips input pin", v, 32'h20);
    bus_wr(ctrl_addr(5), 32'h0);
    bus_wr(12'h060, 32'h20);
    bus_rd(12'h000, v);        check("R3 clear output pin", v, 32'h00);
    bus_wr(ctrl_addr(5), 32'h1);
    bus_wr(ctrl_addr(3), 32'h1);

    // R4 synchroniser latency
    @(negedge clk); gpio_in = 8'hA5;
    bus_rd(12'h020, v);        check("R4 not yet after one edge", v, 32'h00);
    bus_rd(12'h020, v);        check("R4 visible after two edges", v, 32'hA5);
    @(negedge clk); gpio_in = 8'h00;
    repeat (4) @(negedge clk);

    // R5 exhaustive sweep: every pin, every trigger, both edge directions
    for (int p = 0; p < NPIN; p++) begin
      for (int t = 0; t < 4; t++) begin
        bus_wr(ctrl_addr(p), 32'h1 | (32'(t) << 3));
        bus_wr(12'h0C0, 32'h1 << p);
        for (int e = 0; e < 2; e++) begin
          logic rising;
          logic [31:0] exp_bits;
          rising = (e == 0);
          @(negedge clk); gpio_in[p] = rising;
          repeat (2) @(negedge clk);
          bus_rd(12'h080, v);
          exp_bits = expect_hit(t, rising) ? (32'h1 << p) : 32'h0;
          check($sformatf("R5 pin%0d trig%0d %s", p, t, rising ? "rise" : "fall"), v, exp_bits);
          check("R9 irq follows unmasked status", {31'h0, irq}, {31'h0, exp_bits != 0});
          bus_wr(12'h080, 32'h1 << p);
          bus_rd(12'h080, v);   check("R6 w1c clears", v, 32'h0);
        end
        bus_wr(12'h0A0, 32'h1 << p);
      end
      bus_wr(ctrl_addr(p), 32'h1);
    end

    // R8 mask set and clear addresses
    bus_wr(12'h0C0, 32'h3C);
    bus_rd(12'h0A0, v);        check("R8 mask clear", v, 32'hC3);
    bus_wr(12'h0A0, 32'h04);
    bus_rd(12'h0C0, v);        check("R8 mask set, read via clear addr", v, 32'hC7);
    bus_wr(12'h0A0, 32'hFF);

    // R9 masked pending keeps irq low; unmask raises it
    bus_wr(ctrl_addr(0), 32'h09);
    @(negedge clk); gpio_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(12'h080, v);        check("R9 pending while masked", v, 32'h01);
    check("R9 masked irq low", {31'h0, irq}, 32'h0);
    bus_wr(12'h0C0, 32'h01);
    check("R9 unmask raises irq", {31'h0, irq}, 32'h1);

    // R10 sticky: falling back does not clear with rising-only trigger
    @(negedge clk); gpio_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(12'h080, v);        check("R10 status sticky", v, 32'h01);

    // R6 zero bits leave status alone
    bus_wr(12'h080, 32'hFE);
    bus_rd(12'h080, v);        check("R6 zero data no effect", v, 32'h01);

    // R7 edge and clear in the same cycle: bit stays set
    @(negedge clk); gpio_in[0] = 1'b1;      // before edge k
    @(negedge clk);                          // after k
    @(negedge clk);                          // after k+1
    wr_en = 1'b1; addr = 12'h080; wdata = 32'h01;
    @(negedge clk);                          // sampled at k+2 with the hit
    wr_en = 1'b0;
    bus_rd(12'h080, v);        check("R7 edge beats clear", v, 32'h01);
    check("R7 irq still high", {31'h0, irq}, 32'h1);
    bus_wr(12'h080, 32'h01);
    bus_rd(12'h080, v);        check("R7 later clear works", v, 32'h00);
    check("R9 irq drops", {31'h0, irq}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule